// File: doc/BRIEF.md
# Windowed Register File

This block is the general-purpose register file of a 32-bit soft processor whose register names pass through a movable window. An instruction can reach 32 registers by name. Names 0 to 7 always reach the same eight global registers. Names 8 to 31 are translated through a current window pointer into a larger windowed bank. The size of that bank is chosen at elaboration from 128, 256 or 512 registers, and all registers are 32 bits wide.

A call executes a save, and a return executes a restore. A save moves the window down by sixteen registers, so the values the caller placed in its output registers appear in the callee's input registers without being copied. A restore moves the window back up. A save at the lowest window raises a one-cycle underflow flag, and a restore at the highest window raises a one-cycle overflow flag. In both cases the pointer does not move. Spilling and filling windows to memory is the job of trap software, and this block does not do it.

The file has two combinational read ports and one write port that takes effect at the clock edge. The current pointer is visible as an output so that the trap logic can see which window is active.

Top module: `windowed_regfile`

## Requirements
- R1: Logical registers 0 to 7 are globals. A value written to one of them reads back unchanged from either read port under every window pointer value.
- R2: With base = 16 × cwp, logical 8..15 (outputs) map to windowed entries base+0..7, logical 16..23 (locals) map to base+8..15, and logical 24..31 (inputs) map to base+16..23. As a result, the locals of adjacent windows never share storage.
- R3: A save request with cwp above 0 lowers cwp by 1 at the next edge. From the next cycle on, the caller's output n (8..15) reads as input n+16.
- R4: A restore request with cwp below the top lowers nothing and raises cwp by 1 at the next edge. From the next cycle on, the callee's input n (24..31) reads as output n-16.
- R5: A save request while cwp is 0 leaves cwp at 0. It drives underflow high for exactly the one cycle after the request edge.
- R6: A restore request while cwp equals CWP_TOP = (NUM_PHYS-24)/16 leaves cwp unchanged. It drives overflow high for exactly the one cycle after the request edge.
- R7: A read of the register that is being written in the same cycle returns the old value. The new value is readable from the cycle after the write edge.
- R8: After a synchronous active-low reset, cwp equals CWP_TOP (6 when NUM_PHYS is 128), every register reads zero, and both flags are low.
- R9: When save and restore are requested in the same cycle, the pointer does not change and neither flag rises.
- R10: A write that coincides with a save or a restore lands in the register that its logical index names under the pointer value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Logical index for read port A |
| rd_a_data | output | DATA_W | Read port A data, combinational |
| rd_b_idx | input | 5 | Logical index for read port B |
| rd_b_data | output | DATA_W | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical index to write |
| wr_data | input | DATA_W | Write data |
| save_req | input | 1 | Move the window down by one position |
| restore_req | input | 1 | Move the window up by one position |
| cwp | output | CWP_W | Current window pointer |
| underflow | output | 1 | One-cycle pulse: a save was refused |
| overflow | output | 1 | One-cycle pulse: a restore was refused |

## Verification
The read ports have no register, so a read result is due in the same cycle that its index is applied. The bench applies each index after the falling edge and samples 1 ns later, before the next rising edge. Written data, the new pointer and both flags all appear one rising edge after the request. Every request is therefore held for exactly one rising edge and checked after the following falling edge. The same-cycle read-during-write case is sampled twice: once before that edge to see the old value, and once after it to see the new one.

// File: rtl/rwin_pkg.sv
// Package: shared constants and types for the windowed register file.
// Assumes that window geometry is fixed: 8 globals and 24 windowed names per window,
// with a window step of 16.
package rwin_pkg;
    localparam int LIDX_W      = 5;   // logical register index width
    localparam int GLOBAL_CNT  = 8;   // always-visible globals
    localparam int WIN_STEP    = 16;  // registers moved per save/restore
    localparam int WIN_SPAN    = 24;  // windowed names per window

    typedef enum logic [1:0] {
        PTR_HOLD    = 2'd0,
        PTR_SAVE    = 2'd1,
        PTR_RESTORE = 2'd2
    } ptr_op_e;

    // Highest legal window pointer for a given windowed bank depth.
    function automatic int top_window(input int nphys);
        return (nphys - WIN_SPAN) / WIN_STEP;
    endfunction
endpackage

// File: rtl/rwin_ptr.sv
// Module: window pointer with save/restore stepping and refusal flags.
// Assumes that save and restore arriving together cancel each other. The flags are
// registered and last one cycle.
module rwin_ptr
    import rwin_pkg::*;
#(
    parameter int NUM_PHYS = 128,
    parameter int CWP_TOP  = top_window(NUM_PHYS),
    parameter int CWP_W    = $clog2(CWP_TOP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             restore_req,
    output logic [CWP_W-1:0] cwp,
    output logic             underflow,
    output logic             overflow
);
    localparam logic [CWP_W-1:0] TOP = CWP_W'(CWP_TOP);

    ptr_op_e op;
    logic    at_bottom;
    logic    at_top;

    // Decode the requested pointer operation; simultaneous requests hold.
    always_comb begin
        unique case ({restore_req, save_req})
            2'b01:   op = PTR_SAVE;
            2'b10:   op = PTR_RESTORE;
            default: op = PTR_HOLD;
        endcase
    end

    assign at_bottom = (cwp == '0);
    assign at_top    = (cwp == TOP);

    // Step the pointer or flag a refused step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp       <= TOP;
            underflow <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            underflow <= (op == PTR_SAVE) && at_bottom;
            overflow  <= (op == PTR_RESTORE) && at_top;
            if (op == PTR_SAVE && !at_bottom)
                cwp <= cwp - CWP_W'(1);
            else if (op == PTR_RESTORE && !at_top)
                cwp <= cwp + CWP_W'(1);
        end
    end

    assert_save_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && cwp != '0) |=> (cwp == $past(cwp) - CWP_W'(1)));

    assert_restore_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && cwp != TOP) |=> (cwp == $past(cwp) + CWP_W'(1)));

    assert_no_underflow_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && cwp == '0) |=> (underflow && cwp == '0));

    assert_no_overflow_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && cwp == TOP) |=> (overflow && cwp == TOP));

    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> ($stable(cwp) && !underflow && !overflow));

    assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cwp <= TOP);
endmodule

// File: rtl/rwin_map.sv
// Module: translates a logical register name into a global slot or a windowed bank entry.
// Assumes that the window base is 16*cwp and that outputs, locals and inputs are stacked
// upward from that base.
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NUM_PHYS = 128,
    parameter int CWP_W    = 3,
    parameter int PIDX_W   = $clog2(NUM_PHYS)
) (
    input  logic [LIDX_W-1:0] lidx,
    input  logic [CWP_W-1:0]  cwp,
    output logic              is_glb,
    output logic [2:0]        gsel,
    output logic [PIDX_W-1:0] psel
);
    // Split globals from windowed names and compute the bank entry.
    always_comb begin
        is_glb = (int'(lidx) < GLOBAL_CNT);
        gsel   = lidx[2:0];
        if (is_glb)
            psel = '0;
        else
            psel = PIDX_W'(int'(cwp) * WIN_STEP + int'(lidx) - GLOBAL_CNT);
    end
endmodule

// File: rtl/rwin_bank.sv
// Module: register array with one clocked write port and NRD combinational read ports.
// Assumes that a read in the cycle of a write sees the value from before that write.
module rwin_bank #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    parameter int NRD   = 2,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        // Combinational read of entry raddr[r].
        assign rdata[r] = mem[raddr[r]];
    end

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/windowed_regfile.sv
// Module: top of the windowed register file. It holds 8 fixed globals plus a windowed bank
// of NUM_PHYS entries, has two read ports and one write port.
// Assumes NUM_PHYS is 128, 256 or 512, and that writes use the pointer value from before
// the same edge.
module windowed_regfile
    import rwin_pkg::*;
#(
    parameter int NUM_PHYS = 128,
    parameter int DATA_W   = 32,
    parameter int CWP_TOP  = top_window(NUM_PHYS),
    parameter int CWP_W    = $clog2(CWP_TOP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [4:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [4:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              save_req,
    input  logic              restore_req,
    output logic [CWP_W-1:0]  cwp,
    output logic              underflow,
    output logic              overflow
);
    localparam int PIDX_W = $clog2(NUM_PHYS);
    localparam int NPORT  = 3;   // read A, read B, write

    logic [NPORT-1:0][LIDX_W-1:0] lidx_all;
    logic [NPORT-1:0]             is_glb;
    logic [NPORT-1:0][2:0]        gsel;
    logic [NPORT-1:0][PIDX_W-1:0] psel;
    logic [1:0][2:0]              g_raddr;
    logic [1:0][PIDX_W-1:0]       w_raddr;
    logic [1:0][DATA_W-1:0]       g_rdata;
    logic [1:0][DATA_W-1:0]       w_rdata;

    assign lidx_all = {wr_idx, rd_b_idx, rd_a_idx};

    rwin_ptr #(.NUM_PHYS(NUM_PHYS), .CWP_TOP(CWP_TOP), .CWP_W(CWP_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .save_req(save_req), .restore_req(restore_req),
        .cwp(cwp), .underflow(underflow), .overflow(overflow)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwin_map #(.NUM_PHYS(NUM_PHYS), .CWP_W(CWP_W), .PIDX_W(PIDX_W)) u_map (
            .lidx(lidx_all[p]), .cwp(cwp),
            .is_glb(is_glb[p]), .gsel(gsel[p]), .psel(psel[p])
        );
    end

    assign g_raddr = {gsel[1], gsel[0]};
    assign w_raddr = {psel[1], psel[0]};

    rwin_bank #(.DEPTH(GLOBAL_CNT), .DW(DATA_W), .NRD(2)) u_globals (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && is_glb[2]), .waddr(gsel[2]), .wdata(wr_data),
        .raddr(g_raddr), .rdata(g_rdata)
    );

    rwin_bank #(.DEPTH(NUM_PHYS), .DW(DATA_W), .NRD(2)) u_windowed (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && !is_glb[2]), .waddr(psel[2]), .wdata(wr_data),
        .raddr(w_raddr), .rdata(w_rdata)
    );

    // Steer each read port to the bank that its name lives in.
    always_comb begin
        rd_a_data = is_glb[0] ? g_rdata[0] : w_rdata[0];
        rd_b_data = is_glb[1] ? g_rdata[1] : w_rdata[1];
    end

    assert_glb_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx < 5'd8 && $stable(rd_a_idx) && !$past(wr_en) && $past(rst_n))
            |-> $stable(rd_a_data));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(underflow && overflow));
endmodule

// File: tb/windowed_regfile_test.sv
module windowed_regfile_test;
    localparam int NPHYS   = 128;
    localparam int EXP_TOP = (NPHYS - 24) / 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [31:0] rd_a_data, rd_b_data;
    logic [2:0]  cwp;
    logic        underflow, overflow;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    windowed_regfile #(.NUM_PHYS(NPHYS)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .cwp(cwp), .underflow(underflow), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One rising edge with the given request, starting and ending at a falling edge.
    task automatic cyc(input logic s, input logic r, input logic w,
                       input logic [4:0] wi, input logic [31:0] wd);
        save_req = s; restore_req = r; wr_en = w; wr_idx = wi; wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        save_req = 1'b0; restore_req = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rda(input logic [4:0] idx, output logic [31:0] d);
        rd_a_idx = idx; #1; d = rd_a_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R8 cwp", 32'(cwp), 32'(EXP_TOP));
        chk("R8 underflow", 32'(underflow), 0);
        chk("R8 overflow", 32'(overflow), 0);
        rda(5'd2, d);  chk("R8 global zero", d, 0);
        rda(5'd17, d); chk("R8 local zero", d, 0);
        rda(5'd30, d); chk("R8 input zero", d, 0);
    endtask

    task automatic t_globals();
        cyc(0, 0, 1, 5'd3, 32'hC0DE_0003);
        cyc(1, 0, 0, 5'd0, 0);
        rd_b_idx = 5'd3; #1;
        chk("R1 global after save", rd_b_data, 32'hC0DE_0003);
        cyc(0, 1, 0, 5'd0, 0);
        rd_b_idx = 5'd3; #1;
        chk("R1 global after restore", rd_b_data, 32'hC0DE_0003);
    endtask

    task automatic t_overlap();
        logic [31:0] d;
        cyc(0, 0, 1, 5'd10, 32'hA0A0_0010);
        cyc(0, 0, 1, 5'd18, 32'h0000_0018);
        cyc(1, 0, 0, 5'd0, 0);
        chk("R3 cwp after save", 32'(cwp), 32'(EXP_TOP - 1));
        rda(5'd26, d); chk("R3 caller output as callee input", d, 32'hA0A0_0010);
        rda(5'd18, d); chk("R2 callee local private", d, 0);
        cyc(0, 0, 1, 5'd27, 32'hBEEF_0027);
        cyc(0, 1, 0, 5'd0, 0);
        chk("R4 cwp after restore", 32'(cwp), 32'(EXP_TOP));
        rda(5'd11, d); chk("R4 callee input as caller output", d, 32'hBEEF_0027);
        rda(5'd18, d); chk("R2 caller local kept", d, 32'h0000_0018);
    endtask

    task automatic t_same_cycle();
        rd_a_idx = 5'd20;
        wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'hD00D_0020;
        #1;
        chk("R7 old value same cycle", rd_a_data, 0);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R7 new value next cycle", rd_a_data, 32'hD00D_0020);
    endtask

    task automatic t_cancel();
        cyc(1, 1, 0, 5'd0, 0);
        chk("R9 cwp held", 32'(cwp), 32'(EXP_TOP));
        chk("R9 no flags", 32'({underflow, overflow}), 0);
    endtask

    task automatic t_write_with_save();
        logic [31:0] d;
        cyc(1, 0, 1, 5'd12, 32'hE0E0_0012);
        chk("R10 cwp moved", 32'(cwp), 32'(EXP_TOP - 1));
        rda(5'd28, d); chk("R10 write used old window", d, 32'hE0E0_0012);
        cyc(0, 1, 0, 5'd0, 0);
        rda(5'd12, d); chk("R10 readback in old window", d, 32'hE0E0_0012);
    endtask

    task automatic t_underflow();
        for (int i = EXP_TOP; i > 0; i--) begin
            cyc(1, 0, 0, 5'd0, 0);
            chk("R3 step down", 32'(cwp), 32'(i - 1));
            chk("R5 no early underflow", 32'(underflow), 0);
        end
        cyc(1, 0, 0, 5'd0, 0);
        chk("R5 underflow raised", 32'(underflow), 1);
        chk("R5 cwp stays 0", 32'(cwp), 0);
        cyc(0, 0, 0, 5'd0, 0);
        chk("R5 underflow one cycle", 32'(underflow), 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < EXP_TOP; i++) begin
            cyc(0, 1, 0, 5'd0, 0);
            chk("R4 step up", 32'(cwp), 32'(i + 1));
            chk("R6 no early overflow", 32'(overflow), 0);
        end
        cyc(0, 1, 0, 5'd0, 0);
        chk("R6 overflow raised", 32'(overflow), 1);
        chk("R6 cwp stays top", 32'(cwp), 32'(EXP_TOP));
        cyc(0, 0, 0, 5'd0, 0);
        chk("R6 overflow one cycle", 32'(overflow), 0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_globals();
        t_overlap();
        t_same_cycle();
        t_cancel();
        t_write_with_save();
        t_underflow();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule